// File: doc/BRIEF.md
# Cache Injection Credit Controller

This block chooses, for every received packet that is about to be written into host memory, whether the write should land in a host cache or go straight to DRAM. It keeps a count of packets that currently sit in the cache. The count goes up by one for every packet sent to the cache. It goes down when software, having finished with packets, returns acknowledgement packets that carry a number of credits.

While the count is above a programmable threshold, new packets are sent to DRAM and the count does not change. This keeps the cache from overflowing and thrashing, so that packets already in the cache stay there until software consumes them. Traffic is never dropped or held back: only the target changes. The DMA transfer itself happens outside this block.

A status port shows the current count. A sticky flag records that at least one packet has been diverted to DRAM since reset.

Top module: `cache_credit_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `resident_o` is 0 and `diverted_o` is 0.
- R2: `wr_to_cache_o` is 1 (cache) when the registered count is less than or equal to `thresh_i`, and 0 (DRAM) when the count is greater than `thresh_i`. The decision is combinational and uses the count before any update in the same cycle.
- R3: A cycle with `wr_valid_i` high and `wr_to_cache_o` high, and no acknowledgement, raises `resident_o` by exactly one in the next cycle.
- R4: A cycle with `wr_valid_i` high and `wr_to_cache_o` low, and no acknowledgement, leaves `resident_o` unchanged.
- R5: A cycle with `ack_valid_i` high lowers the count by `ack_count_i`. If the credits exceed the count, the count becomes 0 and does not wrap.
- R6: When a cache write and an acknowledgement occur in the same cycle, the next count is count + 1 − `ack_count_i`, clamped at 0, applied in one update.
- R7: The count saturates at its all-ones value (255 by default) and does not wrap on further cache writes.
- R8: `diverted_o` becomes 1 in the cycle after any write sent to DRAM, and stays 1 until reset.
- R9: With `ack_valid_i` low, `ack_count_i` has no effect. With `wr_valid_i` low, no write is counted and `diverted_o` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thresh_i | input | CNT_W | Maximum count at which new packets still go to the cache |
| wr_valid_i | input | 1 | A packet write is being issued this cycle |
| wr_to_cache_o | output | 1 | 1 = send to cache, 0 = send to DRAM |
| ack_valid_i | input | 1 | A software acknowledgement arrives this cycle |
| ack_count_i | input | ACK_W | Number of credits the acknowledgement returns |
| resident_o | output | CNT_W | Current count of packets resident in the cache |
| diverted_o | output | 1 | Sticky: a packet was diverted to DRAM since reset |

## Verification
The bench runs directed sequences and then several thousand random cycles:
- **Threshold crossing.** Writes alone walk the count up to the threshold and over it. This separates a strict "above" comparison from an inclusive one, and shows that diverted packets leave the count unchanged.
- **Large acknowledgements.** Acknowledgements with more credits than the count separate clamping at zero from wrap-around.
- **Simultaneous events.** A write and an acknowledgement in the same cycle separate a single net update from one that drops either event.
- **Saturation.** A long run at the maximum threshold exposes wrap-around at the top of the counter.
- **Ignored inputs.** Cycles with `ack_count_i` non-zero but `ack_valid_i` low show that the credit value is ignored when not flagged.

Random stimulus uses small thresholds and mixed write and acknowledgement rates. This keeps the count moving across the threshold.

// File: rtl/cache_credit_pkg.sv
package cache_credit_pkg;
   function automatic int unsigned cc_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/cc_dest_select.sv
module cc_dest_select #(
   parameter int unsigned CNT_W = 8
) (
   input  logic [CNT_W-1:0] count_i,
   input  logic [CNT_W-1:0] thresh_i,
   output logic             to_cache_o
);
   // Cache while the count has not passed the threshold (R2)
   always_comb to_cache_o = (count_i <= thresh_i);
endmodule

// File: rtl/cc_resident_counter.sv
module cc_resident_counter
   import cache_credit_pkg::*;
#(
   parameter int unsigned CNT_W = 8,
   parameter int unsigned ACK_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_i,
   input  logic             ack_valid_i,
   input  logic [ACK_W-1:0] ack_count_i,
   output logic [CNT_W-1:0] count_o
);
   localparam int unsigned SW = cc_max(CNT_W, ACK_W) + 1;
   localparam logic [SW-1:0] TOP = {{(SW-CNT_W){1'b0}}, {CNT_W{1'b1}}};
   localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic [SW-1:0]    sum_w, sub_w, res_w;

   always_comb begin
      sum_w = SW'(cnt_q) + SW'(inc_i);
      sub_w = ack_valid_i ? SW'(ack_count_i) : '0;
      res_w = (sub_w >= sum_w) ? '0 : (sum_w - sub_w);
      cnt_d = (res_w > TOP) ? CMAX : res_w[CNT_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assign count_o = cnt_q;

   assert_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !ack_valid_i && cnt_q != CMAX) |=> (cnt_q == $past(cnt_q) + 1'b1));
   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc_i && !ack_valid_i) |=> $stable(cnt_q));
   assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid_i && !inc_i) |=> (cnt_q <= $past(cnt_q)));
   assert_saturate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !ack_valid_i && cnt_q == CMAX) |=> (cnt_q == CMAX));
endmodule

// File: rtl/cc_divert_flag.sv
module cc_divert_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic divert_i,
   output logic flag_o
);
   logic flag_q;

   always_ff @(posedge clk) begin
      if (!rst_n)        flag_q <= 1'b0;
      else if (divert_i) flag_q <= 1'b1;
   end

   assign flag_o = flag_q;

   assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flag_q |=> flag_q);
   assert_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      divert_i |=> flag_q);
endmodule

// File: rtl/cache_credit_ctrl.sv
module cache_credit_ctrl #(
   parameter int unsigned CNT_W = 8,
   parameter int unsigned ACK_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] thresh_i,
   input  logic             wr_valid_i,
   output logic             wr_to_cache_o,
   input  logic             ack_valid_i,
   input  logic [ACK_W-1:0] ack_count_i,
   output logic [CNT_W-1:0] resident_o,
   output logic             diverted_o
);
   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
         $error("CNT_W must lie in 2..32");
      end
      if (ACK_W < 1 || ACK_W > 32) begin : g_bad_ack
         $error("ACK_W must lie in 1..32");
      end
   endgenerate

   logic [CNT_W-1:0] count_w;
   logic             to_cache_w;
   logic             inc_w, divert_w;

   cc_dest_select #(.CNT_W(CNT_W)) u_sel (
      .count_i    (count_w),
      .thresh_i   (thresh_i),
      .to_cache_o (to_cache_w)
   );

   assign inc_w    = wr_valid_i &  to_cache_w;
   assign divert_w = wr_valid_i & ~to_cache_w;

   cc_resident_counter #(.CNT_W(CNT_W), .ACK_W(ACK_W)) u_cnt (
      .clk         (clk),
      .rst_n       (rst_n),
      .inc_i       (inc_w),
      .ack_valid_i (ack_valid_i),
      .ack_count_i (ack_count_i),
      .count_o     (count_w)
   );

   cc_divert_flag u_flag (
      .clk      (clk),
      .rst_n    (rst_n),
      .divert_i (divert_w),
      .flag_o   (diverted_o)
   );

   assign wr_to_cache_o = to_cache_w;
   assign resident_o    = count_w;

   assert_dest_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (resident_o > thresh_i) |-> !wr_to_cache_o);
   assert_dest_cache_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (resident_o <= thresh_i) |-> wr_to_cache_o);
   assert_idle_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_valid_i && !diverted_o) |=> !diverted_o);
endmodule

// File: tb/cache_credit_ctrl_tb.sv
`timescale 1ns/1ps
module cache_credit_ctrl_tb;
   localparam int CNT_W = 8;
   localparam int ACK_W = 4;
   localparam int CMAX  = (1 << CNT_W) - 1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [CNT_W-1:0] thresh = '0;
   logic             wr_valid = 1'b0, ack_valid = 1'b0;
   logic [ACK_W-1:0] ack_count = '0;
   logic             to_cache, diverted;
   logic [CNT_W-1:0] resident;

   int vectors = 0, fails = 0;
   int m_cnt = 0;
   bit m_flag = 1'b0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   cache_credit_ctrl #(.CNT_W(CNT_W), .ACK_W(ACK_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .thresh_i(thresh),
      .wr_valid_i(wr_valid), .wr_to_cache_o(to_cache),
      .ack_valid_i(ack_valid), .ack_count_i(ack_count),
      .resident_o(resident), .diverted_o(diverted)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int next_cnt(input int c, input bit inc, input bit a, input int n);
      int s;
      s = c + (inc ? 1 : 0);
      if (a) s = (n >= s) ? 0 : s - n;
      if (s > CMAX) s = CMAX;
      return s;
   endfunction

   // Called at a negative edge
   task automatic step(input bit w, input bit a, input int n, input string tag);
      bit exp_dest;
      wr_valid = w; ack_valid = a; ack_count = ACK_W'(n);
      #1;
      exp_dest = (m_cnt <= int'(thresh));
      chk(to_cache == exp_dest, {tag, " R2 dest"}, int'(to_cache), int'(exp_dest));
      if (w && !exp_dest) m_flag = 1'b1;
      m_cnt = next_cnt(m_cnt, w && exp_dest, a, n);
      @(negedge clk);
      chk(int'(resident) == m_cnt, {tag, " count"}, int'(resident), m_cnt);
      chk(diverted == m_flag, {tag, " R8 flag"}, int'(diverted), int'(m_flag));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      chk(resident == 0, "R1 reset count", int'(resident), 0);
      chk(diverted == 0, "R1 reset flag", int'(diverted), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(resident == 0, "R1 after reset count", int'(resident), 0);
      chk(diverted == 0, "R1 after reset flag", int'(diverted), 0);

      // Threshold crossing: threshold 3 allows counts 0..3 to go to cache
      thresh = 8'd3;
      for (int i = 0; i < 4; i++) step(1, 0, 0, "R3 fill");
      chk(resident == 4, "R3 four cached", int'(resident), 4);
      step(1, 0, 0, "R4 divert");
      chk(resident == 4, "R4 divert keeps count", int'(resident), 4);
      chk(diverted == 1, "R8 set on divert", int'(diverted), 1);
      step(0, 0, 7, "R9 idle");
      step(0, 0, 9, "R9 ack ignored");
      chk(resident == 4, "R9 ack_count without valid", int'(resident), 4);
      step(0, 1, 2, "R5 ack two");
      chk(resident == 2, "R5 ack two", int'(resident), 2);
      step(1, 1, 1, "R6 same cycle");
      chk(resident == 2, "R6 net zero", int'(resident), 2);
      step(1, 1, 0, "R6 zero credit");
      step(0, 1, 15, "R5 clamp");
      chk(resident == 0, "R5 clamp at zero", int'(resident), 0);
      step(1, 1, 5, "R6 clamp");
      chk(resident == 0, "R6 net clamp", int'(resident), 0);
      chk(diverted == 1, "R8 stays set", int'(diverted), 1);

      // Saturation at maximum threshold
      thresh = 8'(CMAX);
      for (int i = 0; i < CMAX + 5; i++) step(1, 0, 0, "R7 sat");
      chk(int'(resident) == CMAX, "R7 saturate", int'(resident), CMAX);

      // Reset clears, then random mix
      rst_n = 1'b0; wr_valid = 0; ack_valid = 0;
      @(negedge clk);
      rst_n = 1'b1; m_cnt = 0; m_flag = 0;
      @(negedge clk);
      chk(resident == 0 && diverted == 0, "R1 re-reset", int'(resident) + int'(diverted), 0);
      for (int i = 0; i < 4000; i++) begin
         if (($urandom % 64) == 0) thresh = 8'($urandom % 20);
         step(($urandom % 10) < 6, ($urandom % 10) < 3, int'($urandom % 16), "R6 random");
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule